// File: doc/BRIEF.md
# Privileged Control Register Access Arbiter

This block holds one 64-bit control word, kept as two stored copies, and decides the fate of every read or write aimed at it. A request arrives with the current privilege level (0 to 3), a direction flag, a flag telling whether the primary or the alias encoding was used, write data, and a set of configuration and debug-state bits. One clock edge later the block answers with exactly one outcome. The access is completed, with read data on a read. It is redirected to a memory slot at a fixed offset. It is declared an undefined instruction. Or it traps to level 2 or level 3 with a syndrome class. Raising the actual exception is left to the surrounding pipeline.

The outcome is not a simple privilege compare. It comes from a fixed priority chain that depends on the privilege level and on the encoding used. The chain also checks fine-grained trap enables, the unit enables for levels 2 and 3, the nested-virtualization bits and the host-mode bit. A debug-halt override, and an optional change in its priority, can sit ahead of the other checks. The primary encoding reaches the level-2 copy. The alias encoding reaches the level-1 copy, except at level 2 with host mode set, where it reaches the level-2 copy.

Top module: `ctlreg_gatekeeper`

## Requirements
- R1: After reset all response outputs are 0 and both stored copies hold zero.
- R2: A request sampled on a clock edge is answered on the following cycle with rsp_valid high and exactly one of rsp_done, rsp_redirect, rsp_undef, rsp_trap_l2, rsp_trap_l3 high; with no request, all of these are low.
- R3: A request at level 0 is undefined, whichever encoding is used.
- R4: At level 1 the primary encoding traps to level 2 when cfg_l2_on is 1 and cfg_nv bit 0 is 1; otherwise it is undefined.
- R5: At level 2, for either encoding, when cfg_l3_here is 1 and cfg_l3_unit_en is 0 the access traps to level 3, or is undefined if dbg_halted and dbg_secure_off are both 1.
- R6: When cfg_l3_first, dbg_halted, dbg_secure_off and cfg_l3_here are all 1 and cfg_l3_unit_en is 0, an alias request at level 1 and any request at level 2 are undefined, ahead of every other check.
- R7: At level 1 with the alias encoding and cfg_l2_on = 1, these trap to level 2, checked in this order: cfg_l3_here = 1 with cfg_fg_l3_en = 0; then the direction's fine-grained allow bit (cfg_fg_rd_ok for reads, cfg_fg_wr_ok for writes) at 0; then cfg_l2_unit_en = 0.
- R8: Next in the level-1 alias chain, cfg_l3_here = 1 with cfg_l3_unit_en = 0 traps to level 3, or is undefined if dbg_halted and dbg_secure_off are both 1.
- R9: Next in the level-1 alias chain, cfg_l2_on = 1 with cfg_nv = 3'b111 gives a redirect with rsp_offset = 12'h8E8, and a write leaves both copies unchanged.
- R10: A level-1 alias request that passes every check completes on the level-1 copy.
- R11: A level-2 request that completes reaches the level-2 copy through the primary encoding, and through the alias encoding when cfg_host is 1. Otherwise the alias reaches the level-1 copy.
- R12: At level 3 every request completes, whatever the configuration: primary on the level-2 copy, alias on the level-1 copy.
- R13: rsp_class is 6'h18 on either trap and zero otherwise. rsp_offset is zero except on a redirect. rsp_rdata carries the addressed copy on a completed read and is zero otherwise.
- R14: A copy changes only on the edge that samples a completed write addressed to it. The stored value is then the write data, and the write's response has rsp_rdata zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_level | input | 2 | Current privilege level 0..3 |
| req_write | input | 1 | 1 = write, 0 = read |
| req_alias | input | 1 | 1 = alias encoding, 0 = primary encoding |
| req_wdata | input | 64 | Write data |
| cfg_l2_on | input | 1 | Level 2 present and enabled |
| cfg_l3_here | input | 1 | Level 3 present |
| cfg_nv | input | 3 | Nested-virtualization bits; bit 0 is the basic enable |
| cfg_host | input | 1 | Host-mode bit for level 2 |
| cfg_fg_l3_en | input | 1 | Level-3 enable for fine-grained traps |
| cfg_fg_rd_ok | input | 1 | Fine-grained allow for alias reads at level 1 |
| cfg_fg_wr_ok | input | 1 | Fine-grained allow for alias writes at level 1 |
| cfg_l2_unit_en | input | 1 | Level-2 enable for the controlled unit |
| cfg_l3_unit_en | input | 1 | Level-3 enable for the controlled unit |
| cfg_l3_first | input | 1 | Puts the halted undefined check ahead of the others |
| dbg_halted | input | 1 | Core halted in debug |
| dbg_secure_off | input | 1 | Secure debug disabled |
| rsp_valid | output | 1 | Response present |
| rsp_done | output | 1 | Access completed |
| rsp_rdata | output | 64 | Read data, completed reads only |
| rsp_redirect | output | 1 | Access redirected to memory slot |
| rsp_offset | output | 12 | Memory slot offset on redirect |
| rsp_undef | output | 1 | Undefined instruction |
| rsp_trap_l2 | output | 1 | Trap to level 2 |
| rsp_trap_l3 | output | 1 | Trap to level 3 |
| rsp_class | output | 6 | Syndrome class on a trap |

## Verification
A completed write and the next request's read of the same copy meet on one clock edge. The edge that stores the write data also answers the next request, and that answer must already show the new value. The bench provokes this by issuing requests back to back with no idle cycle between them, often writing through one encoding and then reading through the other one or the same one. A reference model updates its own copies whenever it predicts a completed write and compares every response field on every cycle. This shows that the read is neither one edge stale nor spoiled by a write that was trapped or redirected.

// File: rtl/ctlreg_gk_pkg.sv
package ctlreg_gk_pkg;

    typedef enum logic [2:0] {
        OC_NONE  = 3'd0,
        OC_DONE  = 3'd1,
        OC_REDIR = 3'd2,
        OC_UNDEF = 3'd3,
        OC_TRAP2 = 3'd4,
        OC_TRAP3 = 3'd5
    } outcome_e;

    // stored copy indices
    localparam int COPY_HI = 0;  // level-2 copy
    localparam int COPY_LO = 1;  // level-1 copy

    typedef struct packed {
        logic       l2_on;
        logic       l3_here;
        logic [2:0] nv;
        logic       host;
        logic       fg_l3_en;
        logic       fg_rd_ok;
        logic       fg_wr_ok;
        logic       l2_unit_en;
        logic       l3_unit_en;
        logic       l3_first;
        logic       halted;
        logic       secure_off;
    } cfg_t;

endpackage

// File: rtl/ctlreg_gk_decide.sv
module ctlreg_gk_decide
    import ctlreg_gk_pkg::*;
#(
    parameter bit FINE_TRAP = 1'b1
) (
    input  logic [1:0] level,
    input  logic       is_alias,
    input  logic       is_write,
    input  cfg_t       cfg,
    output outcome_e   outcome,
    output logic       tgt_lo
);

    logic early_undef;
    logic l3_blocks;
    logic dbg_locked;
    logic fg_dir_ok;
    outcome_e l3_result;

    always_comb begin
        dbg_locked  = cfg.halted && cfg.secure_off;
        l3_blocks   = cfg.l3_here && !cfg.l3_unit_en;
        early_undef = cfg.l3_first && dbg_locked && l3_blocks;
        fg_dir_ok   = is_write ? cfg.fg_wr_ok : cfg.fg_rd_ok;
        l3_result   = dbg_locked ? OC_UNDEF : OC_TRAP3;
    end

    always_comb begin
        outcome = OC_UNDEF;
        tgt_lo  = 1'b0;
        unique case (level)
            2'd0: outcome = OC_UNDEF;
            2'd1: begin
                if (!is_alias) begin
                    outcome = (cfg.l2_on && cfg.nv[0]) ? OC_TRAP2 : OC_UNDEF;
                end else if (early_undef) begin
                    outcome = OC_UNDEF;
                end else if (FINE_TRAP && cfg.l2_on && cfg.l3_here && !cfg.fg_l3_en) begin
                    outcome = OC_TRAP2;
                end else if (FINE_TRAP && cfg.l2_on && !fg_dir_ok) begin
                    outcome = OC_TRAP2;
                end else if (cfg.l2_on && !cfg.l2_unit_en) begin
                    outcome = OC_TRAP2;
                end else if (l3_blocks) begin
                    outcome = l3_result;
                end else if (cfg.l2_on && (&cfg.nv)) begin
                    outcome = OC_REDIR;
                end else begin
                    outcome = OC_DONE;
                    tgt_lo  = 1'b1;
                end
            end
            2'd2: begin
                if (early_undef) begin
                    outcome = OC_UNDEF;
                end else if (l3_blocks) begin
                    outcome = l3_result;
                end else begin
                    outcome = OC_DONE;
                    tgt_lo  = is_alias && !cfg.host;
                end
            end
            default: begin
                outcome = OC_DONE;
                tgt_lo  = is_alias;
            end
        endcase
    end

endmodule

// File: rtl/ctlreg_gk_store.sv
module ctlreg_gk_store #(
    parameter int DATA_W = 64,
    parameter int N_COPY = 2,
    localparam int SEL_W = (N_COPY > 1) ? $clog2(N_COPY) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [SEL_W-1:0]  rd_sel,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] copy_d [N_COPY];
    logic [DATA_W-1:0] copy_q [N_COPY];

    for (genvar g = 0; g < N_COPY; g++) begin : g_copy
        always_comb begin
            copy_d[g] = copy_q[g];
            if (wr_en && (wr_sel == SEL_W'(g))) begin
                copy_d[g] = wr_data;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) copy_q[g] <= '0;
            else        copy_q[g] <= copy_d[g];
        end

        // R14: a copy not selected by a completed write keeps its value
        assert_copy_hold_R14: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && (wr_sel == SEL_W'(g))) |=> $stable(copy_q[g]));
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < N_COPY; i++) begin
            if (rd_sel == SEL_W'(i)) rd_data = copy_q[i];
        end
    end

endmodule

// File: rtl/ctlreg_gatekeeper.sv
module ctlreg_gatekeeper
    import ctlreg_gk_pkg::*;
#(
    parameter int          DATA_W    = 64,
    parameter int          OFF_W     = 12,
    parameter int          CLS_W     = 6,
    parameter logic [11:0] SLOT_OFF  = 12'h8E8,
    parameter logic [5:0]  TRAP_CLS  = 6'h18,
    parameter bit          FINE_TRAP = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_level,
    input  logic              req_write,
    input  logic              req_alias,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              cfg_l2_on,
    input  logic              cfg_l3_here,
    input  logic [2:0]        cfg_nv,
    input  logic              cfg_host,
    input  logic              cfg_fg_l3_en,
    input  logic              cfg_fg_rd_ok,
    input  logic              cfg_fg_wr_ok,
    input  logic              cfg_l2_unit_en,
    input  logic              cfg_l3_unit_en,
    input  logic              cfg_l3_first,
    input  logic              dbg_halted,
    input  logic              dbg_secure_off,
    output logic              rsp_valid,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_redirect,
    output logic [OFF_W-1:0]  rsp_offset,
    output logic              rsp_undef,
    output logic              rsp_trap_l2,
    output logic              rsp_trap_l3,
    output logic [CLS_W-1:0]  rsp_class
);

    localparam int N_COPY = 2;
    localparam int SEL_W  = 1;

    typedef struct packed {
        logic              valid;
        logic              done;
        logic              redir;
        logic              undef;
        logic              trap2;
        logic              trap3;
        logic [DATA_W-1:0] rdata;
        logic [OFF_W-1:0]  offset;
        logic [CLS_W-1:0]  cls;
    } rsp_t;

    cfg_t              cfg;
    outcome_e          outcome;
    logic              tgt_lo;
    logic              wr_en;
    logic [DATA_W-1:0] rd_data;
    rsp_t              rsp_d;
    rsp_t              rsp_q;

    always_comb begin
        cfg.l2_on      = cfg_l2_on;
        cfg.l3_here    = cfg_l3_here;
        cfg.nv         = cfg_nv;
        cfg.host       = cfg_host;
        cfg.fg_l3_en   = cfg_fg_l3_en;
        cfg.fg_rd_ok   = cfg_fg_rd_ok;
        cfg.fg_wr_ok   = cfg_fg_wr_ok;
        cfg.l2_unit_en = cfg_l2_unit_en;
        cfg.l3_unit_en = cfg_l3_unit_en;
        cfg.l3_first   = cfg_l3_first;
        cfg.halted     = dbg_halted;
        cfg.secure_off = dbg_secure_off;
    end

    ctlreg_gk_decide #(
        .FINE_TRAP (FINE_TRAP)
    ) u_decide (
        .level    (req_level),
        .is_alias (req_alias),
        .is_write (req_write),
        .cfg      (cfg),
        .outcome  (outcome),
        .tgt_lo   (tgt_lo)
    );

    ctlreg_gk_store #(
        .DATA_W (DATA_W),
        .N_COPY (N_COPY)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (SEL_W'(tgt_lo)),
        .wr_data (req_wdata),
        .rd_sel  (SEL_W'(tgt_lo)),
        .rd_data (rd_data)
    );

    always_comb begin
        rsp_d = '0;
        wr_en = 1'b0;
        if (req_valid) begin
            rsp_d.valid = 1'b1;
            unique case (outcome)
                OC_DONE: begin
                    rsp_d.done = 1'b1;
                    if (req_write) wr_en = 1'b1;
                    else           rsp_d.rdata = rd_data;
                end
                OC_REDIR: begin
                    rsp_d.redir  = 1'b1;
                    rsp_d.offset = OFF_W'(SLOT_OFF);
                end
                OC_TRAP2: begin
                    rsp_d.trap2 = 1'b1;
                    rsp_d.cls   = CLS_W'(TRAP_CLS);
                end
                OC_TRAP3: begin
                    rsp_d.trap3 = 1'b1;
                    rsp_d.cls   = CLS_W'(TRAP_CLS);
                end
                default: rsp_d.undef = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid    = rsp_q.valid;
    assign rsp_done     = rsp_q.done;
    assign rsp_rdata    = rsp_q.rdata;
    assign rsp_redirect = rsp_q.redir;
    assign rsp_offset   = rsp_q.offset;
    assign rsp_undef    = rsp_q.undef;
    assign rsp_trap_l2  = rsp_q.trap2;
    assign rsp_trap_l3  = rsp_q.trap3;
    assign rsp_class    = rsp_q.cls;

    // R2: request answered on the next cycle, idle otherwise
    assert_answer_next_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid && !rsp_done && !rsp_redirect && !rsp_undef
                       && !rsp_trap_l2 && !rsp_trap_l3);
    assert_one_outcome_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $onehot({rsp_done, rsp_redirect, rsp_undef, rsp_trap_l2, rsp_trap_l3}));

    // R3: level 0 is always undefined
    assert_level0_undef_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_level == 2'd0) |=> rsp_undef);

    // R12: level 3 always completes
    assert_level3_done_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_level == 2'd3) |=> rsp_done);

    // R13: class only on traps, offset only on redirect
    assert_class_trap_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_trap_l2 || rsp_trap_l3) |-> rsp_class == CLS_W'(TRAP_CLS));
    assert_class_zero_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_trap_l2 || rsp_trap_l3) |-> rsp_class == '0);
    assert_offset_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_redirect |-> rsp_offset == OFF_W'(SLOT_OFF));

    // R14: a write response never carries read data
    assert_write_no_data_R14: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write) |=> rsp_rdata == '0);

endmodule

// File: tb/ctlreg_gatekeeper_bench.sv
`timescale 1ns/1ps
module ctlreg_gatekeeper_bench;

    localparam int OC_NONE = 0, OC_DONE = 1, OC_REDIR = 2, OC_UNDEF = 3,
                   OC_TRAP2 = 4, OC_TRAP3 = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_level = '0;
    logic        req_write = 1'b0;
    logic        req_alias = 1'b0;
    logic [63:0] req_wdata = '0;
    logic        cfg_l2_on = 1'b1, cfg_l3_here = 1'b1, cfg_host = 1'b0;
    logic [2:0]  cfg_nv = '0;
    logic        cfg_fg_l3_en = 1'b1, cfg_fg_rd_ok = 1'b1, cfg_fg_wr_ok = 1'b1;
    logic        cfg_l2_unit_en = 1'b1, cfg_l3_unit_en = 1'b1, cfg_l3_first = 1'b0;
    logic        dbg_halted = 1'b0, dbg_secure_off = 1'b0;
    logic        rsp_valid, rsp_done, rsp_redirect, rsp_undef, rsp_trap_l2, rsp_trap_l3;
    logic [63:0] rsp_rdata;
    logic [11:0] rsp_offset;
    logic [5:0]  rsp_class;

    always #4 clk = ~clk;

    ctlreg_gatekeeper u_ctlreg_gatekeeper (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_level(req_level),
        .req_write(req_write), .req_alias(req_alias), .req_wdata(req_wdata),
        .cfg_l2_on(cfg_l2_on), .cfg_l3_here(cfg_l3_here), .cfg_nv(cfg_nv),
        .cfg_host(cfg_host), .cfg_fg_l3_en(cfg_fg_l3_en), .cfg_fg_rd_ok(cfg_fg_rd_ok),
        .cfg_fg_wr_ok(cfg_fg_wr_ok), .cfg_l2_unit_en(cfg_l2_unit_en),
        .cfg_l3_unit_en(cfg_l3_unit_en), .cfg_l3_first(cfg_l3_first),
        .dbg_halted(dbg_halted), .dbg_secure_off(dbg_secure_off),
        .rsp_valid(rsp_valid), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
        .rsp_redirect(rsp_redirect), .rsp_offset(rsp_offset), .rsp_undef(rsp_undef),
        .rsp_trap_l2(rsp_trap_l2), .rsp_trap_l3(rsp_trap_l3), .rsp_class(rsp_class)
    );

    int errors = 0;
    int checks = 0;
    logic [63:0] m_hi = '0;   // model level-2 copy
    logic [63:0] m_lo = '0;   // model level-1 copy
    bit          pend = 1'b0;
    int          exp_oc = OC_NONE;
    logic [63:0] exp_rdata = '0;
    bit          exp_wr = 1'b0;
    string       exp_tag = "R2";

    // Reference decision written from the requirement list
    function automatic int decide(input int lvl, input bit wr, input bit al,
                                  output bit lo, output string tag);
        bit locked   = dbg_halted && dbg_secure_off;
        bit blocked3 = cfg_l3_here && !cfg_l3_unit_en;
        bit first    = cfg_l3_first && locked && blocked3;
        lo = 1'b0;
        if (lvl == 0) begin tag = "R3"; return OC_UNDEF; end
        if (lvl == 3) begin tag = "R12"; lo = al; return OC_DONE; end
        if (lvl == 2) begin
            if (first) begin tag = "R6"; return OC_UNDEF; end
            if (blocked3) begin tag = "R5"; return locked ? OC_UNDEF : OC_TRAP3; end
            tag = "R11"; lo = al && !cfg_host; return OC_DONE;
        end
        if (!al) begin
            tag = "R4";
            return (cfg_l2_on && cfg_nv[0]) ? OC_TRAP2 : OC_UNDEF;
        end
        if (first) begin tag = "R6"; return OC_UNDEF; end
        tag = "R7";
        if (cfg_l2_on && cfg_l3_here && !cfg_fg_l3_en) return OC_TRAP2;
        if (cfg_l2_on && !(wr ? cfg_fg_wr_ok : cfg_fg_rd_ok)) return OC_TRAP2;
        if (cfg_l2_on && !cfg_l2_unit_en) return OC_TRAP2;
        if (blocked3) begin tag = "R8"; return locked ? OC_UNDEF : OC_TRAP3; end
        if (cfg_l2_on && cfg_nv == 3'b111) begin tag = "R9"; return OC_REDIR; end
        tag = "R10"; lo = 1'b1; return OC_DONE;
    endfunction

    function automatic int seen();
        int n = int'(rsp_done) + int'(rsp_redirect) + int'(rsp_undef)
              + int'(rsp_trap_l2) + int'(rsp_trap_l3);
        if (n == 0) return OC_NONE;
        if (n > 1)  return 9;
        if (rsp_done) return OC_DONE;
        if (rsp_redirect) return OC_REDIR;
        if (rsp_undef) return OC_UNDEF;
        if (rsp_trap_l2) return OC_TRAP2;
        return OC_TRAP3;
    endfunction

    task automatic check_pending();
        int act;
        logic [5:0]  ecls;
        logic [11:0] eoff;
        if (!pend) return;
        act = seen();
        checks++;
        if (act != exp_oc || rsp_valid != (exp_oc != OC_NONE)) begin
            errors++;
            $display("FAIL %s outcome: actual=%0d valid=%0b expected=%0d", exp_tag, act,
                     rsp_valid, exp_oc);
        end
        checks++;
        if (rsp_rdata !== exp_rdata) begin
            errors++;
            $display("FAIL %s rdata: actual=%h expected=%h", exp_wr ? "R14" : "R13",
                     rsp_rdata, exp_rdata);
        end
        ecls = (exp_oc == OC_TRAP2 || exp_oc == OC_TRAP3) ? 6'h18 : 6'h00;
        eoff = (exp_oc == OC_REDIR) ? 12'h8E8 : 12'h000;
        checks++;
        if (rsp_class !== ecls || rsp_offset !== eoff) begin
            errors++;
            $display("FAIL R13 class/offset: actual=%h/%h expected=%h/%h", rsp_class,
                     rsp_offset, ecls, eoff);
        end
    endtask

    // Called at a falling edge: check last response, drive next request
    task automatic step(input bit v, input int lvl, input bit wr, input bit al,
                        input logic [63:0] d);
        bit lo;
        string tag;
        int oc;
        check_pending();
        req_valid = v; req_level = 2'(lvl); req_write = wr; req_alias = al; req_wdata = d;
        if (!v) begin
            exp_oc = OC_NONE; exp_rdata = '0; exp_wr = 1'b0; exp_tag = "R2";
        end else begin
            oc = decide(lvl, wr, al, lo, tag);
            exp_oc = oc; exp_tag = tag; exp_wr = wr; exp_rdata = '0;
            if (oc == OC_DONE) begin
                if (!wr) exp_rdata = lo ? m_lo : m_hi;
                else if (lo) m_lo = d;
                else m_hi = d;
            end
        end
        pend = 1'b1;
        @(negedge clk);
    endtask

    task automatic open_cfg();
        cfg_l2_on = 1; cfg_l3_here = 1; cfg_nv = 3'b000; cfg_host = 0;
        cfg_fg_l3_en = 1; cfg_fg_rd_ok = 1; cfg_fg_wr_ok = 1;
        cfg_l2_unit_en = 1; cfg_l3_unit_en = 1; cfg_l3_first = 0;
        dbg_halted = 0; dbg_secure_off = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R2 watchdog: actual=hung expected=finished");
        $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: outputs quiet after reset
        checks++;
        if (rsp_valid || rsp_done || rsp_redirect || rsp_undef || rsp_trap_l2
            || rsp_trap_l3 || rsp_rdata != 0 || rsp_class != 0 || rsp_offset != 0) begin
            errors++;
            $display("FAIL R1 reset outputs: actual=%b expected=0",
                     {rsp_valid, rsp_done, rsp_redirect, rsp_undef, rsp_trap_l2, rsp_trap_l3});
        end
        open_cfg();
        // R1: both copies read zero at level 3
        step(1, 3, 0, 0, '0); exp_tag = "R1";
        step(1, 3, 0, 1, '0); exp_tag = "R1";
        // R12: level 3 direct access to both copies
        step(1, 3, 1, 0, 64'hA5A5_0000_1111_2222);
        step(1, 3, 1, 1, 64'h0F0F_3333_4444_5555);
        step(1, 3, 0, 0, '0);
        step(1, 3, 0, 1, '0);
        // R11: level 2 copy selection
        step(1, 2, 0, 0, '0);
        step(1, 2, 0, 1, '0);
        cfg_host = 1;
        step(1, 2, 0, 1, '0);
        step(1, 2, 1, 1, 64'hC0DE_C0DE_0000_0001);
        step(1, 2, 0, 0, '0);           // back-to-back read of just-written copy
        cfg_host = 0;
        step(1, 2, 1, 1, 64'hBEEF_0000_0000_0002);
        step(1, 3, 0, 1, '0);
        // R3: level 0
        step(1, 0, 0, 0, '0);
        step(1, 0, 1, 1, 64'h1);
        // R4: level 1 primary
        cfg_nv = 3'b001;
        step(1, 1, 0, 0, '0);
        cfg_l2_on = 0;
        step(1, 1, 1, 0, 64'h2);
        cfg_l2_on = 1; cfg_nv = 3'b000;
        step(1, 1, 0, 0, '0);
        // R10: level 1 alias normal access
        step(1, 1, 0, 1, '0);
        step(1, 1, 1, 1, 64'h1234_5678_9ABC_DEF0);
        step(1, 1, 0, 1, '0);
        // R7: fine-grained and level-2 enable traps
        cfg_fg_l3_en = 0;
        step(1, 1, 0, 1, '0);
        cfg_fg_l3_en = 1; cfg_fg_rd_ok = 0;
        step(1, 1, 0, 1, '0);
        step(1, 1, 1, 1, 64'h7777);
        cfg_fg_rd_ok = 1; cfg_l2_unit_en = 0;
        step(1, 1, 1, 1, 64'h8888);
        cfg_l2_unit_en = 1;
        // R8: level-3 enable at level 1 alias
        cfg_l3_unit_en = 0;
        step(1, 1, 0, 1, '0);
        dbg_halted = 1; dbg_secure_off = 1;
        step(1, 1, 1, 1, 64'h9999);
        // R5: level 2 against level-3 enable
        step(1, 2, 0, 0, '0);
        dbg_secure_off = 0;
        step(1, 2, 1, 1, 64'hAAAA);
        cfg_l3_here = 0;
        step(1, 2, 0, 1, '0);
        cfg_l3_here = 1;
        // R6: priority bit puts the halted undefined first
        dbg_secure_off = 1; cfg_fg_l3_en = 0; cfg_l3_first = 1;
        step(1, 1, 0, 1, '0);
        step(1, 2, 1, 0, 64'hBBBB);
        cfg_l3_first = 0;
        step(1, 1, 0, 1, '0);
        open_cfg();
        // R9: redirect, write leaves copies alone
        cfg_nv = 3'b111;
        step(1, 1, 1, 1, 64'hDEAD_DEAD_DEAD_DEAD);
        step(1, 3, 0, 1, '0);
        step(1, 3, 0, 0, '0);
        cfg_nv = 3'b000;
        step(0, 0, 0, 0, '0);
        // Randomized back-to-back traffic
        for (int i = 0; i < 4000; i++) begin
            cfg_l2_on      = ($urandom_range(0, 3) != 0);
            cfg_l3_here    = ($urandom_range(0, 3) != 0);
            cfg_nv         = ($urandom_range(0, 2) == 0) ? 3'b111 : 3'($urandom);
            cfg_host       = 1'($urandom);
            cfg_fg_l3_en   = ($urandom_range(0, 4) != 0);
            cfg_fg_rd_ok   = ($urandom_range(0, 4) != 0);
            cfg_fg_wr_ok   = ($urandom_range(0, 4) != 0);
            cfg_l2_unit_en = ($urandom_range(0, 4) != 0);
            cfg_l3_unit_en = ($urandom_range(0, 3) != 0);
            cfg_l3_first   = 1'($urandom);
            dbg_halted     = ($urandom_range(0, 2) == 0);
            dbg_secure_off = 1'($urandom);
            step(($urandom_range(0, 4) != 0), int'($urandom_range(0, 3)), 1'($urandom),
                 1'($urandom), {$urandom, $urandom});
        end
        step(0, 0, 0, 0, '0);
        check_pending();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule